// File: doc/BRIEF.md
# Multi-mode DMA channel engine

A single DMA channel that copies data units from a source address to a destination address through a single-beat memory master port. Software sets it up through a small word-addressed register port: start addresses, a transfer count, a group size, a signed offset and a mode word. It then enables the channel and triggers work either through a software start bit or through a hardware request line.

Each unit takes one read beat followed by one write beat. After each unit, each side's address moves according to its own update mode. Three transfer types are supported. Normal moves one unit per request. Repeat moves one unit per request and returns the chosen area's address to its start value after every group. Block moves a whole group per request and then returns the chosen area's address to its start value.

When the count runs out, the channel disables itself and raises an end flag. The end flag can drive an interrupt.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads 0, and `mem_req_o`, `irq_o` and `active_o` are 0.
- R2: The register word addresses are as follows.
  - 0: source start. A read returns the current source address.
  - 1: destination start. A read returns the current destination address.
  - 2: count, bits 25:0.
  - 3: group size, bits 15:0.
  - 4: mode word. Bits 1:0 transfer type, 3:2 area select, 5:4 unit size, 7:6 trigger, 9:8 source update mode, 11:10 destination update mode, 12 end-interrupt enable.
  - 5: offset.
  - 6: enable, bit 0.
  - 7: start bit in bit 0 and keep bit in bit 1.
  - 8: status. Bit 0 is active (read-only) and bit 1 is the end flag.
- R3: Each unit is a read beat at the current source address. The write beat at the current destination address follows in the next cycle. The write carries the read data, which the memory returns in the cycle after the read beat. `mem_size_o` equals the unit size code.
- R4: Update mode codes are 00 fixed, 01 add the offset (signed, 32-bit), 10 add the unit bytes, 11 subtract the unit bytes. Unit size codes are 00 for 1 byte, 01 for 2 bytes and 10 for 4 bytes.
- R5: Type 00 (normal) moves one unit per accepted request, and the count drops by one per unit.
- R6: Type 01 (repeat) moves one unit per request, and the count drops per unit. After every group-size units, the area side's address returns to its start value instead of stepping.
- R7: Type 10 (block) moves group-size units per request without re-checking the trigger. The count drops by one per block, and the area side's address returns to its start value after the block.
- R8: Area select 00 means destination, 01 means source, and 10 means that neither side's address is reloaded.
- R9: A group size of 0 means 65,536 units.
- R10: Trigger 00 uses the start bit. Trigger 01 uses `hw_req_i` sampled while the channel is idle, and in that mode the start bit starts nothing.
- R11: With keep = 0, the start bit clears when a request is accepted. With keep = 1, it stays set and requests repeat until the count ends.
- R12: When the count reaches zero, the enable bit clears and the end flag sets. `active_o` (status bit 0) is 1 only while a request is being serviced. `irq_o` is the end flag ANDed with the end-interrupt enable. Writing status with bit 1 = 0 clears the end flag, and writing 1 has no effect.
- R13: Type 11, size 11, area 11 or trigger 1x start no beat and leave the count and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address (read and write) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| hw_req_i | input | 1 | Hardware transfer request |
| mem_req_o | output | 1 | Memory beat valid |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat address |
| mem_size_o | output | 2 | Beat unit size code |
| mem_wdata_o | output | 32 | Write beat data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read beat |
| irq_o | output | 1 | End-of-transfer interrupt |
| active_o | output | 1 | Request being serviced |

## Verification
A sweep covers every pairing of the source and destination update modes with every unit size in normal mode. Each write address and each data word is compared against arithmetic expectations, which separates the offset sign, the step width and per-side independence.

Repeat and block runs use different area selects. These separate a reload on the destination side from one on the source side, and per-unit count updates from per-block ones.

A group size of 0 is run to the full 65,536 units. Separate runs exercise the keep bit, the hardware trigger, the interrupt enable and each prohibited encoding, and they check that no beat issues and no state moves.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {XF_NORMAL = 2'd0, XF_REPEAT = 2'd1, XF_BLOCK = 2'd2, XF_BAD = 2'd3} xfer_e;
  typedef enum logic [1:0] {AREA_DST = 2'd0, AREA_SRC = 2'd1, AREA_NONE = 2'd2, AREA_BAD = 2'd3} area_e;
  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_OFFSET = 2'd1, AM_INC = 2'd2, AM_DEC = 2'd3} amode_e;

  typedef struct packed {
    logic       irq_en;
    amode_e     dmode;
    amode_e     smode;
    logic [1:0] trig;
    logic [1:0] size;
    area_e      area;
    xfer_e      xtype;
  } mode_t;

  localparam logic [3:0] RA_SRC   = 4'd0;
  localparam logic [3:0] RA_DST   = 4'd1;
  localparam logic [3:0] RA_CNT   = 4'd2;
  localparam logic [3:0] RA_GRP   = 4'd3;
  localparam logic [3:0] RA_MODE  = 4'd4;
  localparam logic [3:0] RA_OFS   = 4'd5;
  localparam logic [3:0] RA_CTRL  = 4'd6;
  localparam logic [3:0] RA_START = 4'd7;
  localparam logic [3:0] RA_STAT  = 4'd8;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 26,
  parameter int GW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] src_cur_i,
  input  logic [AW-1:0] dst_cur_i,
  input  logic          busy_i,
  input  logic          take_i,
  input  logic          cnt_dec_i,
  input  logic          done_i,
  output mode_t         cfg_o,
  output logic [AW-1:0] src_start_o,
  output logic [AW-1:0] dst_start_o,
  output logic [AW-1:0] ofs_o,
  output logic [CW-1:0] cnt_o,
  output logic [GW-1:0] grp_o,
  output logic          en_o,
  output logic          sw_o,
  output logic          end_o,
  output logic          src_load_o,
  output logic          dst_load_o,
  output logic          grp_load_o
);
  localparam int MW = $bits(mode_t);

  logic keep_q;

  assign src_load_o = we_i && addr_i == RA_SRC;
  assign dst_load_o = we_i && addr_i == RA_DST;
  assign grp_load_o = we_i && (addr_i == RA_GRP || (addr_i == RA_CTRL && wdata_i[0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o       <= '0;
      src_start_o <= '0;
      dst_start_o <= '0;
      ofs_o       <= '0;
      grp_o       <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_SRC:  src_start_o <= wdata_i[AW-1:0];
        RA_DST:  dst_start_o <= wdata_i[AW-1:0];
        RA_GRP:  grp_o       <= wdata_i[GW-1:0];
        RA_MODE: cfg_o       <= mode_t'(wdata_i[MW-1:0]);
        RA_OFS:  ofs_o       <= wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      en_o   <= 1'b0;
      sw_o   <= 1'b0;
      keep_q <= 1'b0;
      end_o  <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_CNT) cnt_o <= wdata_i[CW-1:0];
      else if (cnt_dec_i)            cnt_o <= cnt_o - CW'(1);

      if (we_i && addr_i == RA_CTRL) en_o <= wdata_i[0];
      else if (done_i)                en_o <= 1'b0;

      if (we_i && addr_i == RA_START) begin
        sw_o   <= wdata_i[0];
        keep_q <= wdata_i[1];
      end else if (take_i && cfg_o.trig == 2'b00 && !keep_q) begin
        sw_o <= 1'b0;
      end

      if (done_i)                                  end_o <= 1'b1;
      else if (we_i && addr_i == RA_STAT && !wdata_i[1]) end_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_SRC:   rdata_o[AW-1:0] = src_cur_i;
      RA_DST:   rdata_o[AW-1:0] = dst_cur_i;
      RA_CNT:   rdata_o[CW-1:0] = cnt_o;
      RA_GRP:   rdata_o[GW-1:0] = grp_o;
      RA_MODE:  rdata_o[MW-1:0] = cfg_o;
      RA_OFS:   rdata_o[AW-1:0] = ofs_o;
      RA_CTRL:  rdata_o[0]      = en_o;
      RA_START: rdata_o[1:0]    = {keep_q, sw_o};
      RA_STAT:  rdata_o[1:0]    = {end_o, busy_i};
      default:  ;
    endcase
  end

  // R12
  end_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_o) |-> $past(done_i));

  // R12
  en_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_o) && !$past(we_i && addr_i == RA_CTRL)) |-> $past(done_i));

  // R11
  autoclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && cfg_o.trig == 2'b00 && !keep_q && !(we_i && addr_i == RA_START)) |=> !sw_o);
endmodule

// File: rtl/dma_chan_agen.sv
module dma_chan_agen
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic [AW-1:0] start_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  amode_e        mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] ofs_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] bytes, nxt;

  assign bytes = AW'(1) << size_i;

  always_comb begin
    case (mode_i)
      AM_FIXED:  nxt = cur_o;
      AM_OFFSET: nxt = cur_o + ofs_i;
      AM_INC:    nxt = cur_o + bytes;
      default:   nxt = cur_o - bytes;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_o <= '0;
    else if (load_i) cur_o <= load_val_i;
    else if (step_i) cur_o <= reload_i ? start_i : nxt;
  end

  // R4
  fixed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reload_i && !load_i && mode_i == AM_FIXED) |=> $stable(cur_o));

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && reload_i && !load_i) |=> cur_o == $past(start_i));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CW = 26,
  parameter int GW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_t         cfg_i,
  input  logic          en_i,
  input  logic          sw_i,
  input  logic          hw_req_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [GW-1:0] grp_i,
  input  logic          grp_load_i,
  output logic          take_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          src_rl_o,
  output logic          dst_rl_o,
  output logic          cnt_dec_o,
  output logic          done_o,
  output logic          busy_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;
  localparam logic [GW:0] GRP_MAX = {1'b1, {GW{1'b0}}};

  st_e         st_q;
  logic [GW:0] left_q, grp_full;
  logic        legal, req, grp_end, seg_end;

  assign legal    = cfg_i.xtype != XF_BAD && cfg_i.size != 2'b11 &&
                    cfg_i.area != AREA_BAD && !cfg_i.trig[1];
  assign req      = cfg_i.trig[0] ? hw_req_i : sw_i;
  assign take_o   = st_q == ST_IDLE && en_i && legal && req;
  assign rd_o     = st_q == ST_RD;
  assign wr_o     = st_q == ST_WR;
  assign busy_o   = st_q != ST_IDLE;
  assign grp_full = (grp_i == '0) ? GRP_MAX : {1'b0, grp_i};

  assign grp_end   = cfg_i.xtype != XF_NORMAL && left_q == (GW+1)'(1);
  assign cnt_dec_o = wr_o && (cfg_i.xtype != XF_BLOCK || grp_end);
  assign done_o    = cnt_dec_o && cnt_i == CW'(1);
  assign seg_end   = cfg_i.xtype != XF_BLOCK || grp_end;
  assign src_rl_o  = wr_o && grp_end && cfg_i.area == AREA_SRC;
  assign dst_rl_o  = wr_o && grp_end && cfg_i.area == AREA_DST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (take_o) st_q <= ST_RD;
        ST_RD:   st_q <= ST_WR;
        default: st_q <= seg_end ? ST_IDLE : ST_RD;
      endcase
    end
  end

  // units left in the current repeat/block group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         left_q <= GRP_MAX;
    else if (grp_load_i) left_q <= grp_full;
    else if (wr_o && cfg_i.xtype != XF_NORMAL)
      left_q <= grp_end ? grp_full : left_q - (GW+1)'(1);
  end

  // R3
  rd_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);

  // R13
  bad_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !legal) |=> !rd_o);

  // R7
  blk_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && cfg_i.xtype == XF_BLOCK && !grp_end) |=> rd_o);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 26,
  parameter int GW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          hw_req_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          irq_o,
  output logic          active_o
);
  mode_t         cfg;
  logic [AW-1:0] src_start, dst_start, ofs;
  logic [CW-1:0] cnt;
  logic [GW-1:0] grp;
  logic          en, sw, end_flag, src_load, dst_load, grp_load;
  logic          take, rd, wr, src_rl, dst_rl, cnt_dec, done, busy;

  logic   [1:0][AW-1:0] cur, start;
  logic   [1:0]         ld, rl;
  amode_e               am [2];

  assign start = {dst_start, src_start};
  assign ld    = {dst_load, src_load};
  assign rl    = {dst_rl, src_rl};
  assign am[0] = cfg.smode;
  assign am[1] = cfg.dmode;

  dma_chan_regs #(.AW(AW), .DW(DW), .CW(CW), .GW(GW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .src_cur_i(cur[0]), .dst_cur_i(cur[1]), .busy_i(busy),
    .take_i(take), .cnt_dec_i(cnt_dec), .done_i(done),
    .cfg_o(cfg), .src_start_o(src_start), .dst_start_o(dst_start), .ofs_o(ofs),
    .cnt_o(cnt), .grp_o(grp), .en_o(en), .sw_o(sw), .end_o(end_flag),
    .src_load_o(src_load), .dst_load_o(dst_load), .grp_load_o(grp_load)
  );

  dma_chan_ctrl #(.CW(CW), .GW(GW)) u_ctrl (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .en_i(en), .sw_i(sw), .hw_req_i(hw_req_i),
    .cnt_i(cnt), .grp_i(grp), .grp_load_i(grp_load),
    .take_o(take), .rd_o(rd), .wr_o(wr), .src_rl_o(src_rl), .dst_rl_o(dst_rl),
    .cnt_dec_o(cnt_dec), .done_o(done), .busy_o(busy)
  );

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_chan_agen #(.AW(AW)) u_agen (
      .clk_i, .rst_ni,
      .load_i(ld[g]), .load_val_i(reg_wdata_i[AW-1:0]), .start_i(start[g]),
      .step_i(wr), .reload_i(rl[g]), .mode_i(am[g]), .size_i(cfg.size),
      .ofs_i(ofs), .cur_o(cur[g])
    );
  end

  assign mem_req_o   = rd | wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = rd ? cur[0] : cur[1];
  assign mem_size_o  = cfg.size;
  assign mem_wdata_o = mem_rdata_i;
  assign irq_o       = end_flag & cfg.irq_en;
  assign active_o    = busy;
endmodule

// File: tb/dma_chan_test.sv
module dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hw = 1'b0;
  logic        mreq, mwe, irq, act;
  logic [31:0] maddr, mwdata;
  logic [1:0]  msize;
  logic [31:0] mrdata = '0;

  int n_chk = 0, n_fail = 0, nw = 0;
  bit fin = 1'b0;
  logic [31:0] wa [0:1023];
  logic [31:0] wd [0:1023];
  logic [1:0]  ws [0:1023];

  localparam logic [31:0] S = 32'h0000_1000;
  localparam logic [31:0] D = 32'h0000_2000;

  always #10 clk = ~clk;

  dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hw_req_i(hw), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_size_o(msize), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .irq_o(irq), .active_o(act)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] mw(int xt, int ar, int sz, int tg, int sm, int dm, int ie);
    return 32'((ie << 12) | (dm << 10) | (sm << 8) | (tg << 6) | (sz << 4) | (ar << 2) | xt);
  endfunction

  function automatic logic [31:0] stp(int m, int sz);
    case (m)
      0: return 32'h0;
      1: return 32'hFFFF_FFF0;
      2: return 32'(1 << sz);
      default: return -32'(1 << sz);
    endcase
  endfunction

  always @(posedge clk) begin
    if (mreq && !mwe) mrdata <= pat(maddr);
    if (mreq && mwe) begin
      if (nw < 1024) begin
        wa[nw] <= maddr;
        wd[nw] <= mwdata;
        ws[nw] <= msize;
      end
      nw <= nw + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) act=hang exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, sa, da;
    int base;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    for (int r = 0; r <= 8; r++) begin
      rd(4'(r), v);
      chk($sformatf("R1 reg %0d after reset", r), v, 32'h0);
    end
    chk("R1 mem_req_o idle", {31'h0, mreq}, 32'h0);
    chk("R1 irq_o idle", {31'h0, irq}, 32'h0);
    chk("R1 active_o idle", {31'h0, act}, 32'h0);

    // R4 R5 R3 sweep: normal mode, all update mode pairs, all sizes
    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 4; sm++)
        for (int dm = 0; dm < 4; dm++) begin
          base = nw;
          wr(4'd0, S); wr(4'd1, D); wr(4'd5, 32'hFFFF_FFF0);
          wr(4'd2, 32'd3); wr(4'd3, 32'd1);
          wr(4'd4, mw(0, 0, sz, 0, sm, dm, 0));
          wr(4'd6, 32'd1); wr(4'd7, 32'd3);
          cyc(15);
          chk($sformatf("R5 units sz%0d s%0d d%0d", sz, sm, dm), 32'(nw - base), 32'd3);
          for (int k = 0; k < 3; k++) begin
            sa = S + 32'(k) * stp(sm, sz);
            da = D + 32'(k) * stp(dm, sz);
            chk($sformatf("R4 dst addr sz%0d s%0d d%0d u%0d", sz, sm, dm, k), wa[base+k], da);
            chk($sformatf("R3 data sz%0d s%0d d%0d u%0d", sz, sm, dm, k), wd[base+k], pat(sa));
            chk($sformatf("R3 size sz%0d u%0d", sz, k), {30'h0, ws[base+k]}, 32'(sz));
          end
          rd(4'd6, v);
          chk("R12 enable cleared at end", v, 32'h0);
          if (sz == 2 && sm == 3 && dm == 3) begin
            rd(4'd7, v);
            chk("R11 keep=1 start bit stays", v, 32'h3);
          end
          wr(4'd7, 32'd0);
        end

    // R11 auto-clear, R5 count, R2 readback
    wr(4'd8, 32'd0);
    base = nw;
    wr(4'd0, S); wr(4'd1, D); wr(4'd2, 32'd3); wr(4'd4, mw(0, 0, 2, 0, 2, 2, 0));
    wr(4'd6, 32'd1); wr(4'd7, 32'd1);
    cyc(10);
    chk("R11 one unit per start", 32'(nw - base), 32'd1);
    rd(4'd7, v); chk("R11 start bit auto-cleared", v, 32'h0);
    rd(4'd2, v); chk("R5 count after one unit", v, 32'd2);
    rd(4'd8, v); chk("R12 status idle between requests", v, 32'h0);
    wr(4'd7, 32'd1); cyc(10);
    wr(4'd7, 32'd1); cyc(10);
    chk("R5 three starts three units", 32'(nw - base), 32'd3);
    rd(4'd2, v); chk("R12 count zero", v, 32'h0);
    rd(4'd6, v); chk("R12 enable cleared", v, 32'h0);
    rd(4'd8, v); chk("R12 end flag set", v, 32'h2);
    chk("R12 irq masked", {31'h0, irq}, 32'h0);
    rd(4'd0, v); chk("R2 source readback", v, S + 32'd12);
    rd(4'd1, v); chk("R2 destination readback", v, D + 32'd12);

    // R12 interrupt enable and flag clear
    wr(4'd8, 32'd0);
    wr(4'd2, 32'd1); wr(4'd4, mw(0, 0, 2, 0, 2, 2, 1));
    wr(4'd6, 32'd1); wr(4'd7, 32'd1);
    cyc(10);
    chk("R12 irq raised", {31'h0, irq}, 32'h1);
    wr(4'd8, 32'h2);
    chk("R12 writing 1 keeps flag", {31'h0, irq}, 32'h1);
    wr(4'd8, 32'h0);
    chk("R12 writing 0 clears flag", {31'h0, irq}, 32'h0);

    // R13 prohibited encodings
    for (int b = 0; b < 4; b++) begin
      base = nw;
      wr(4'd2, 32'd1);
      case (b)
        0: wr(4'd4, mw(3, 0, 0, 0, 2, 2, 0));
        1: wr(4'd4, mw(0, 0, 3, 0, 2, 2, 0));
        2: wr(4'd4, mw(0, 3, 0, 0, 2, 2, 0));
        default: wr(4'd4, mw(0, 0, 0, 2, 2, 2, 0));
      endcase
      wr(4'd6, 32'd1); wr(4'd7, 32'd3);
      cyc(10);
      chk($sformatf("R13 no beat case %0d", b), 32'(nw - base), 32'd0);
      rd(4'd2, v); chk($sformatf("R13 count kept case %0d", b), v, 32'd1);
      rd(4'd6, v); chk($sformatf("R13 enable kept case %0d", b), v, 32'd1);
      wr(4'd6, 32'd0); wr(4'd7, 32'd0);
    end

    // R6 R8 repeat, area destination, group 2, 4-byte units
    base = nw;
    wr(4'd0, S); wr(4'd1, D); wr(4'd2, 32'd5); wr(4'd3, 32'd2);
    wr(4'd4, mw(1, 0, 2, 0, 2, 2, 0));
    wr(4'd6, 32'd1); wr(4'd7, 32'd3);
    cyc(25);
    chk("R6 repeat units", 32'(nw - base), 32'd5);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R6 repeat dst u%0d", k), wa[base+k], D + 32'(4 * (k % 2)));
      chk($sformatf("R8 repeat src not reloaded u%0d", k), wd[base+k], pat(S + 32'(4 * k)));
    end
    rd(4'd1, v); chk("R6 dst after repeat", v, D + 32'd4);
    rd(4'd0, v); chk("R8 src after repeat", v, S + 32'd20);
    wr(4'd7, 32'd0);

    // R7 R8 R10 block, area source, group 3, 2-byte units, hardware trigger
    base = nw;
    wr(4'd0, S); wr(4'd1, D); wr(4'd2, 32'd2); wr(4'd3, 32'd3);
    wr(4'd4, mw(2, 1, 1, 1, 2, 2, 0));
    wr(4'd6, 32'd1);
    wr(4'd7, 32'd3);
    cyc(10);
    chk("R10 start bit ignored with hw trigger", 32'(nw - base), 32'd0);
    wr(4'd7, 32'd0);
    @(negedge clk); hw = 1'b1;
    @(negedge clk); hw = 1'b0;
    cyc(10);
    chk("R7 one request one block", 32'(nw - base), 32'd3);
    rd(4'd2, v); chk("R7 count per block", v, 32'd1);
    rd(4'd6, v); chk("R7 enable after first block", v, 32'd1);
    rd(4'd0, v); chk("R8 src reloaded after block", v, S);
    rd(4'd1, v); chk("R8 dst keeps stepping", v, D + 32'd6);
    @(negedge clk); hw = 1'b1;
    @(negedge clk); hw = 1'b0;
    cyc(10);
    chk("R10 second request second block", 32'(nw - base), 32'd6);
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R7 block dst u%0d", k), wa[base+k], D + 32'(2 * k));
      chk($sformatf("R7 block data u%0d", k), wd[base+k], pat(S + 32'(2 * (k % 3))));
    end
    rd(4'd6, v); chk("R12 enable cleared after blocks", v, 32'h0);

    // R9 group size zero, area none
    base = nw;
    wr(4'd0, S); wr(4'd1, D); wr(4'd2, 32'd1); wr(4'd3, 32'd0);
    wr(4'd4, mw(2, 2, 0, 0, 0, 2, 0));
    wr(4'd6, 32'd1); wr(4'd7, 32'd1);
    cyc(100);
    chk("R12 active during block", {31'h0, act}, 32'h1);
    cyc(131200);
    chk("R9 65536 units", 32'(nw - base), 32'd65536);
    rd(4'd6, v); chk("R9 enable cleared", v, 32'h0);
    rd(4'd1, v); chk("R8 area none dst not reloaded", v, D + 32'd65536);
    rd(4'd0, v); chk("R4 fixed src", v, S);
    chk("R12 active low at end", {31'h0, act}, 32'h0);

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule